// File: doc/BRIEF.md
# Comparator Output Conditioning and Edge Interrupt

This block sits behind an analog comparator and turns its raw decision bit into a clean system signal. The raw bit is gated by the comparator enable and then optionally inverted. The result either passes straight through or is held in a register that only reloads when a timer clock falls. The timer clock can be the timer's source clock or its prescaled clock. Because the capture happens on the falling edge, a timer that counts on the rising edge never sees the comparator change in the middle of an increment.

The conditioned output is carried into the system clock domain. There, two detectors look for rising and falling transitions, and each detector has its own enable. An enabled transition sets a sticky flag, which stays set until software clears it. An interrupt-enable input gates the flag onto the request line. Changing the polarity or switching the comparator on or off also changes the output, so these actions can raise the flag by themselves. The block also decodes two 2-bit input selectors into one-hot routing controls for the analog front end.

Top module: `cmp_cond`

## Requirements
- R1: After reset `cmp_out_o`, `flag_o` and `irq_o` are 0, and both routing vectors are all zero while the comparator is disabled.
- R2: With sync off, `cmp_out_o` equals `(cmp_en_i & cmp_raw_i) ^ pol_inv_i` combinationally.
- R3: While `cmp_en_i` is 0 the raw bit is treated as 0, so `cmp_out_o` equals `pol_inv_i`, and both routing vectors are all zero.
- R4: With sync on, `cmp_out_o` holds the value captured when the selected timer clock falls. The new value appears at the third rising system-clock edge after the fall. A rising timer edge never captures.
- R5: `presc_sel_i` = 0 selects `tmr_src_clk_i` as the capture clock and 1 selects `tmr_presc_clk_i`. Falling edges of the unselected clock are ignored.
- R6: With `rise_en_i` set, a 0-to-1 change of `cmp_out_o` sets `flag_o` at the third rising system-clock edge after the change.
- R7: With `fall_en_i` set, a 1-to-0 change of `cmp_out_o` sets `flag_o` with the same latency. A transition whose detector is disabled leaves the flag unchanged.
- R8: `flag_o` stays set until `flag_clr_i` is high at a rising clock edge, which clears it.
- R9: If an enabled transition and a clear fall in the same cycle, `flag_o` ends up set.
- R10: Toggling `pol_inv_i`, or switching `cmp_en_i`, while the comparator is disabled raises the flag through the enabled detectors.
- R11: `irq_o` is high only while both `flag_o` and `irq_en_i` are high. The flag records transitions whatever the value of `irq_en_i`.
- R12: While the comparator is enabled, `pos_route_o` has only bit `pos_sel_i` set, and `neg_route_o` has only bit `neg_sel_i` set. Positive codes are 0 external pin, 1 DAC level, 2 fixed reference, 3 analog ground. Negative codes 0 to 3 name four external pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Raw comparator decision |
| cmp_en_i | input | 1 | Comparator enable |
| pol_inv_i | input | 1 | Output inversion |
| sync_en_i | input | 1 | Hold output between falling timer-clock edges |
| tmr_src_clk_i | input | 1 | Timer source clock level |
| tmr_presc_clk_i | input | 1 | Timer prescaled clock level |
| presc_sel_i | input | 1 | Capture on prescaled clock when 1 |
| rise_en_i | input | 1 | Rising-transition detector enable |
| fall_en_i | input | 1 | Falling-transition detector enable |
| flag_clr_i | input | 1 | Software clear of the flag |
| irq_en_i | input | 1 | Interrupt request enable |
| pos_sel_i | input | SEL_W | Positive input select |
| neg_sel_i | input | SEL_W | Negative input select |
| cmp_out_o | output | 1 | Conditioned comparator output |
| flag_o | output | 1 | Sticky transition flag |
| irq_o | output | 1 | Interrupt request |
| pos_route_o | output | 2**SEL_W | One-hot positive routing |
| neg_route_o | output | 2**SEL_W | One-hot negative routing |

## Verification
The hardest case to reach is a set and a clear landing on the same clock edge. To hit it, the stimulus changes the output, counts exactly two rising edges, and then raises the clear so that it covers the third edge, where the flag is set. The timer-capture path is driven by toggling the two timer-clock levels by hand. This makes it possible to show that a rise of either clock, or a fall of the unselected clock, leaves the held value alone. Each check is placed one edge before and one edge after the expected update, which pins the capture latency.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
   localparam int unsigned SEL_W = 2;
   localparam int unsigned SYNC_STAGES = 2;

   typedef enum logic [SEL_W-1:0] {
      POS_PIN    = 2'd0,
      POS_DAC    = 2'd1,
      POS_FIXREF = 2'd2,
      POS_GND    = 2'd3
   } pos_src_e;
endpackage

// File: rtl/cmp_sync_chain.sv
module cmp_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("cmp_sync_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg <= '0;
      else         stg <= {stg[STAGES-2:0], d_i};
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cmp_polarity_sync.sv
module cmp_polarity_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cmp_raw_i,
   input  logic cmp_en_i,
   input  logic pol_inv_i,
   input  logic sync_en_i,
   input  logic tmr_src_clk_i,
   input  logic tmr_presc_clk_i,
   input  logic presc_sel_i,
   output logic cmp_out_o,
   output logic fall_tick_o
);
   logic pol_val;
   logic cap_clk;
   logic cap_clk_s;
   logic cap_clk_prev;
   logic held;

   // disabled comparator contributes a 0 before the inversion
   assign pol_val = (cmp_raw_i & cmp_en_i) ^ pol_inv_i;
   assign cap_clk = presc_sel_i ? tmr_presc_clk_i : tmr_src_clk_i;

   cmp_sync_chain #(.STAGES(SYNC_STAGES)) tclk_sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cap_clk),
      .q_o   (cap_clk_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cap_clk_prev <= 1'b0;
      else         cap_clk_prev <= cap_clk_s;
   end

   assign fall_tick_o = cap_clk_prev & ~cap_clk_s;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          held <= 1'b0;
      else if (fall_tick_o) held <= pol_val;
   end

   assign cmp_out_o = sync_en_i ? held : pol_val;
endmodule

// File: rtl/cmp_edge_irq.sv
module cmp_edge_irq #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic cond_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   input  logic clr_i,
   output logic flag_o
);
   logic cond_s;
   logic cond_prev;
   logic hit;

   cmp_sync_chain #(.STAGES(SYNC_STAGES)) out_sync_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cond_i),
      .q_o   (cond_s)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cond_prev <= 1'b0;
      else         cond_prev <= cond_s;
   end

   assign hit = (rise_en_i & cond_s & ~cond_prev) |
                (fall_en_i & ~cond_s & cond_prev);

   // a detected transition outranks a software clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    flag_o <= 1'b0;
      else if (hit)   flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
   end
endmodule

// File: rtl/cmp_input_route.sv
module cmp_input_route #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned NSRC = 1 << SEL_W
) (
   input  logic             en_i,
   input  logic [SEL_W-1:0] pos_sel_i,
   input  logic [SEL_W-1:0] neg_sel_i,
   output logic [NSRC-1:0]  pos_route_o,
   output logic [NSRC-1:0]  neg_route_o
);
   for (genvar k = 0; k < NSRC; k++) begin : g_dec
      assign pos_route_o[k] = en_i && (pos_sel_i == SEL_W'(k));
      assign neg_route_o[k] = en_i && (neg_sel_i == SEL_W'(k));
   end
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
   import cmp_cond_pkg::*;
#(
   parameter int unsigned SYNC_W = cmp_cond_pkg::SYNC_STAGES,
   parameter int unsigned SEL_W  = cmp_cond_pkg::SEL_W,
   localparam int unsigned NSRC  = 1 << SEL_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cmp_raw_i,
   input  logic             cmp_en_i,
   input  logic             pol_inv_i,
   input  logic             sync_en_i,
   input  logic             tmr_src_clk_i,
   input  logic             tmr_presc_clk_i,
   input  logic             presc_sel_i,
   input  logic             rise_en_i,
   input  logic             fall_en_i,
   input  logic             flag_clr_i,
   input  logic             irq_en_i,
   input  logic [SEL_W-1:0] pos_sel_i,
   input  logic [SEL_W-1:0] neg_sel_i,
   output logic             cmp_out_o,
   output logic             flag_o,
   output logic             irq_o,
   output logic [NSRC-1:0]  pos_route_o,
   output logic [NSRC-1:0]  neg_route_o
);
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("cmp_cond: SEL_W must be in 1..4");
   end

   logic fall_tick;

   cmp_polarity_sync #(.SYNC_STAGES(SYNC_W)) pol_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cmp_raw_i      (cmp_raw_i),
      .cmp_en_i       (cmp_en_i),
      .pol_inv_i      (pol_inv_i),
      .sync_en_i      (sync_en_i),
      .tmr_src_clk_i  (tmr_src_clk_i),
      .tmr_presc_clk_i(tmr_presc_clk_i),
      .presc_sel_i    (presc_sel_i),
      .cmp_out_o      (cmp_out_o),
      .fall_tick_o    (fall_tick)
   );

   cmp_edge_irq #(.SYNC_STAGES(SYNC_W)) edge_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cond_i   (cmp_out_o),
      .rise_en_i(rise_en_i),
      .fall_en_i(fall_en_i),
      .clr_i    (flag_clr_i),
      .flag_o   (flag_o)
   );

   cmp_input_route #(.SEL_W(SEL_W)) route_i (
      .en_i       (cmp_en_i),
      .pos_sel_i  (pos_sel_i),
      .neg_sel_i  (neg_sel_i),
      .pos_route_o(pos_route_o),
      .neg_route_o(neg_route_o)
   );

   assign irq_o = flag_o & irq_en_i;
endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned NSRC = 1 << SEL_W
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            cmp_en_i,
   input logic            sync_en_i,
   input logic            rise_en_i,
   input logic            fall_en_i,
   input logic            flag_clr_i,
   input logic            cmp_out_o,
   input logic            flag_o,
   input logic            irq_o,
   input logic [NSRC-1:0] pos_route_o,
   input logic [NSRC-1:0] neg_route_o,
   input logic            fall_tick
);
   // R8
   flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o && !flag_clr_i |=> flag_o);

   // R11
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flag_o |-> !irq_o);

   // R6
   flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o) |-> ($past(rise_en_i) || $past(fall_en_i)));

   // R3
   route_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cmp_en_i |-> (pos_route_o == '0 && neg_route_o == '0));

   // R12
   route_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmp_en_i |-> ($countones(pos_route_o) == 1 && $countones(neg_route_o) == 1));

   // R4
   sync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sync_en_i && $past(sync_en_i) && !$past(fall_tick) |-> $stable(cmp_out_o));
endmodule

bind cmp_cond cmp_cond_chk #(.SEL_W(SEL_W)) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cmp_en_i   (cmp_en_i),
   .sync_en_i  (sync_en_i),
   .rise_en_i  (rise_en_i),
   .fall_en_i  (fall_en_i),
   .flag_clr_i (flag_clr_i),
   .cmp_out_o  (cmp_out_o),
   .flag_o     (flag_o),
   .irq_o      (irq_o),
   .pos_route_o(pos_route_o),
   .neg_route_o(neg_route_o),
   .fall_tick  (fall_tick)
);

// File: tb/cmp_cond_tb_top.sv
module cmp_cond_tb_top;
   import cmp_cond_pkg::*;

   localparam int CLK_PERIOD = 40;

   typedef struct {
      string req;
      string what;
      int    exp;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_raw = 1'b0, cmp_en = 1'b0, pol_inv = 1'b0, sync_en = 1'b0;
   logic       src_clk = 1'b0, presc_clk = 1'b0, presc_sel = 1'b0;
   logic       rise_en = 1'b0, fall_en = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
   logic [1:0] pos_sel = 2'd0, neg_sel = 2'd0;
   logic       cmp_out, flag, irq;
   logic [3:0] pos_route, neg_route;

   item_t exp_q[$];
   event  sample_ev;
   int    n_checks = 0;
   int    n_errors = 0;
   bit    done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_cond dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cmp_raw_i(cmp_raw), .cmp_en_i(cmp_en),
      .pol_inv_i(pol_inv), .sync_en_i(sync_en), .tmr_src_clk_i(src_clk),
      .tmr_presc_clk_i(presc_clk), .presc_sel_i(presc_sel),
      .rise_en_i(rise_en), .fall_en_i(fall_en), .flag_clr_i(flag_clr),
      .irq_en_i(irq_en), .pos_sel_i(pos_sel), .neg_sel_i(neg_sel),
      .cmp_out_o(cmp_out), .flag_o(flag), .irq_o(irq),
      .pos_route_o(pos_route), .neg_route_o(neg_route)
   );

   // monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(sample_ev);
         while (exp_q.size() > 0) begin
            item_t it;
            int act;
            it = exp_q.pop_front();
            case (it.what)
               "out":   act = int'(cmp_out);
               "flag":  act = int'(flag);
               "irq":   act = int'(irq);
               "pos":   act = int'(pos_route);
               default: act = int'(neg_route);
            endcase
            n_checks++;
            if (act != it.exp) begin
               n_errors++;
               $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what, act, it.exp);
            end
         end
      end
   end

   task automatic expect_v(string req, string what, int exp);
      item_t it;
      #1;
      it.req = req; it.what = what; it.exp = exp;
      exp_q.push_back(it);
      -> sample_ev;
      #1;
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD*5000);
      if (!done) begin
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      expect_v("R1", "out", 0);
      expect_v("R1", "flag", 0);
      expect_v("R1", "irq", 0);
      expect_v("R1", "pos", 0);
      tick(1);
      expect_v("R1", "neg", 0);

      // R3 routing off while disabled
      pos_sel = POS_FIXREF;
      expect_v("R3", "pos", 0);
      tick(1);
      // R12 routing decode
      cmp_en = 1'b1;
      for (int k = 0; k < 4; k++) begin
         pos_sel = 2'(k);
         neg_sel = 2'(3 - k);
         expect_v("R12", "pos", 1 << k);
         expect_v("R12", "neg", 1 << (3 - k));
         tick(1);
      end

      // R2 polarity pass-through
      cmp_raw = 1'b1; expect_v("R2", "out", 1);
      pol_inv = 1'b1; expect_v("R2", "out", 0);
      tick(1);
      cmp_raw = 1'b0; expect_v("R2", "out", 1);
      pol_inv = 1'b0; expect_v("R2", "out", 0);
      tick(4);
      // R7 transitions with both detectors disabled leave the flag clear
      expect_v("R7", "flag", 0);

      // R3 disabled comparator forces raw to 0
      cmp_en = 1'b0; cmp_raw = 1'b1;
      expect_v("R3", "out", 0);
      pol_inv = 1'b1;
      expect_v("R3", "out", 1);
      pol_inv = 1'b0;
      tick(4);

      // R6 rising detector and its latency
      rise_en = 1'b1;
      cmp_en = 1'b1;
      expect_v("R6", "out", 1);
      tick(2);
      expect_v("R6", "flag", 0);
      tick(1);
      expect_v("R6", "flag", 1);
      // R11 flag records regardless of the interrupt enable
      expect_v("R11", "irq", 0);
      irq_en = 1'b1;
      expect_v("R11", "irq", 1);
      irq_en = 1'b0;

      // R8 sticky until cleared
      tick(5);
      expect_v("R8", "flag", 1);
      clear_flag();
      expect_v("R8", "flag", 0);

      // R7 falling detector
      rise_en = 1'b0; fall_en = 1'b1;
      cmp_raw = 1'b0;
      tick(3);
      expect_v("R7", "flag", 1);
      clear_flag();
      expect_v("R7", "flag", 0);
      cmp_raw = 1'b1;
      tick(4);
      expect_v("R7", "flag", 0);

      // R9 set wins over a simultaneous clear
      cmp_raw = 1'b0;
      tick(2);
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
      expect_v("R9", "flag", 1);
      clear_flag();
      expect_v("R9", "flag", 0);

      // R10 polarity and enable toggles raise the flag while disabled
      rise_en = 1'b1; fall_en = 1'b1;
      cmp_en = 1'b0;
      tick(4);
      clear_flag();
      pol_inv = 1'b1;
      tick(3);
      expect_v("R10", "flag", 1);
      clear_flag();
      pol_inv = 1'b0;
      tick(3);
      expect_v("R10", "flag", 1);
      clear_flag();
      expect_v("R10", "flag", 0);
      cmp_raw = 1'b1;
      cmp_en = 1'b1;
      tick(3);
      expect_v("R10", "flag", 1);
      clear_flag();
      rise_en = 1'b0; fall_en = 1'b0;

      // R4 capture on falling timer clock
      sync_en = 1'b1;
      expect_v("R4", "out", 0);
      src_clk = 1'b1;
      tick(4);
      expect_v("R4", "out", 0);
      src_clk = 1'b0;
      tick(2);
      expect_v("R4", "out", 0);
      tick(1);
      expect_v("R4", "out", 1);
      cmp_raw = 1'b0;
      expect_v("R4", "out", 1);

      // R5 prescaled clock selection
      presc_sel = 1'b1;
      src_clk = 1'b1;
      tick(4);
      src_clk = 1'b0;
      tick(4);
      expect_v("R5", "out", 1);
      presc_clk = 1'b1;
      tick(4);
      expect_v("R5", "out", 1);
      presc_clk = 1'b0;
      tick(3);
      expect_v("R5", "out", 0);

      tick(2);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule